// File: doc/BRIEF.md
# Registered Command Buffer with Selectable Chip-Select Steering

This block sits between a memory controller and a module's DRAM devices. On each rising clock edge it captures an address/command word, a group of active-low chip selects, the clock-enable lines and the on-die-termination lines. One clock later it presents them as registered outputs. The address/command word is driven twice, once to an A-side copy and once to a B-side copy, so that two rows of devices each see a private, lightly loaded net.

A strap input, sampled while reset is held, fixes how the chip selects are steered. With the strap high, only the two low chip-select inputs are used, and each one drives a pair output on both the A side and the B side. With the strap low, all four chip-select inputs are used, and each drives one output of a four-wide group. Every chip-select output that the selected mode leaves unused is parked inactive (high). A B-side disable input lets a module that populates only one side switch off the B-side outputs, which removes their toggling. Clock-enable and termination lines are registered alongside the other inputs and are never affected by the B-side disable.

Top module: `cmdbuf_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the following edge-registered outputs are set: every chip-select output (`cs_pair_a_o`, `cs_pair_b_o`, `cs_quad_o`) becomes all ones, and `cmd_a_o`, `cmd_b_o`, `cke_o` and `odt_o` become all zeros.
- R2: Out of reset, `cmd_a_o` equals the value `cmd_i` had at the previous rising edge, a latency of exactly one clock.
- R3: Out of reset, when `b_side_off` was low at the previous edge, `cmd_b_o` equals `cmd_a_o`.
- R4: When `b_side_off` was high at the previous edge, `cmd_b_o` is all zeros and `cs_pair_b_o` is all ones. `cmd_a_o` and `cs_quad_o` are unaffected.
- R5: In pair mode (strap = 1), `cs_pair_a_o` and `cs_pair_b_o` each carry the previous edge's `cs_n_i[1:0]` (bit n to bit n). `cs_quad_o` stays all ones, and `cs_n_i[3:2]` has no effect on any output.
- R6: In quad mode (strap = 0), `cs_quad_o[n]` carries the previous edge's `cs_n_i[n]` for n = 0..3, while `cs_pair_a_o` and `cs_pair_b_o` stay all ones.
- R7: The mode is taken from `cs_mode_strap` only at edges where `rst_n` is low. After that, changes on the strap have no effect until the next reset.
- R8: Out of reset, `cke_o` and `odt_o` equal `cke_i` and `odt_i` from the previous edge, whatever the state of `b_side_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_mode_strap | input | 1 | 1 = pair mode (two chip selects, duplicated), 0 = quad mode (four chip selects) |
| b_side_off | input | 1 | Disable B-side command and chip-select outputs |
| cmd_i | input | CMD_W (24) | Address/command word |
| cs_n_i | input | 2*NPAIR (4) | Active-low chip selects |
| cke_i | input | NCKE (2) | Clock-enable controls |
| odt_i | input | NODT (2) | On-die-termination controls |
| cmd_a_o | output | CMD_W (24) | A-side command copy |
| cmd_b_o | output | CMD_W (24) | B-side command copy |
| cs_pair_a_o | output | NPAIR (2) | A-side chip selects, pair mode |
| cs_pair_b_o | output | NPAIR (2) | B-side chip selects, pair mode |
| cs_quad_o | output | 2*NPAIR (4) | One-to-one chip selects, quad mode |
| cke_o | output | NCKE (2) | Registered clock enables |
| odt_o | output | NODT (2) | Registered termination controls |

## Verification
The bench flips the strap while the block runs out of reset. A design that tracked the strap live would then swap its chip-select steering in the middle of traffic, and the bench would see it. Random values on the upper chip selects in pair mode expose a design that leaks them into the quad group or into the pair outputs. Runs in both modes exercise the parking of unused outputs, so a design that left them floating, or drove them low, would assert a rank falsely. Random toggling of the B-side disable would reveal gating applied to the A side or to the clock-enable and termination lines. The first cycle after reset release checks that the one-clock latency holds from the very first capture.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
    typedef enum logic {
        CS_QUAD = 1'b0,
        CS_PAIR = 1'b1
    } cs_mode_e;
endpackage

// File: rtl/cmdbuf_cs_steer.sv
module cmdbuf_cs_steer
    import cmdbuf_pkg::*;
#(
    parameter int NPAIR = 2
) (
    input  cs_mode_e               mode_i,
    input  logic [2*NPAIR-1:0]     cs_n_i,
    input  logic                   b_off_i,
    output logic [NPAIR-1:0]       pair_a_o,
    output logic [NPAIR-1:0]       pair_b_o,
    output logic [2*NPAIR-1:0]     quad_o
);
    // Unused outputs are parked inactive (high) in either mode.
    always_comb begin
        pair_a_o = '1;
        pair_b_o = '1;
        quad_o   = '1;
        if (mode_i == CS_PAIR) begin
            pair_a_o = cs_n_i[NPAIR-1:0];
            pair_b_o = b_off_i ? '1 : cs_n_i[NPAIR-1:0];
        end else begin
            quad_o = cs_n_i;
        end
    end
endmodule

// File: rtl/cmdbuf_fanout.sv
module cmdbuf_fanout #(
    parameter int W      = 24,
    parameter int COPIES = 2
) (
    input  logic [W-1:0]              d_i,
    input  logic [COPIES-1:0]         off_i,
    output logic [COPIES-1:0][W-1:0]  q_o
);
    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        assign q_o[c] = off_i[c] ? '0 : d_i;
    end
endmodule

// File: rtl/cmdbuf_top.sv
module cmdbuf_top
    import cmdbuf_pkg::*;
#(
    parameter int CMD_W = 24,
    parameter int NPAIR = 2,
    parameter int NCKE  = 2,
    parameter int NODT  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_mode_strap,
    input  logic                 b_side_off,
    input  logic [CMD_W-1:0]     cmd_i,
    input  logic [2*NPAIR-1:0]   cs_n_i,
    input  logic [NCKE-1:0]      cke_i,
    input  logic [NODT-1:0]      odt_i,
    output logic [CMD_W-1:0]     cmd_a_o,
    output logic [CMD_W-1:0]     cmd_b_o,
    output logic [NPAIR-1:0]     cs_pair_a_o,
    output logic [NPAIR-1:0]     cs_pair_b_o,
    output logic [2*NPAIR-1:0]   cs_quad_o,
    output logic [NCKE-1:0]      cke_o,
    output logic [NODT-1:0]      odt_o
);
    localparam int NQUAD  = 2 * NPAIR;
    localparam int SIDE_A = 0;
    localparam int SIDE_B = 1;

    typedef struct packed {
        cs_mode_e            mode;
        logic [CMD_W-1:0]    cmd_a;
        logic [CMD_W-1:0]    cmd_b;
        logic [NPAIR-1:0]    cs_pa;
        logic [NPAIR-1:0]    cs_pb;
        logic [NQUAD-1:0]    cs_qd;
        logic [NCKE-1:0]     cke;
        logic [NODT-1:0]     odt;
    } state_t;

    state_t state_d, state_q;

    logic [1:0][CMD_W-1:0] side_cmd_d;
    logic [NPAIR-1:0]      pair_a_d, pair_b_d;
    logic [NQUAD-1:0]      quad_d;

    cmdbuf_fanout #(.W(CMD_W), .COPIES(2)) i_fanout (
        .d_i   (cmd_i),
        .off_i ({b_side_off, 1'b0}),
        .q_o   (side_cmd_d)
    );

    cmdbuf_cs_steer #(.NPAIR(NPAIR)) i_cs_steer (
        .mode_i   (state_q.mode),
        .cs_n_i   (cs_n_i),
        .b_off_i  (b_side_off),
        .pair_a_o (pair_a_d),
        .pair_b_o (pair_b_d),
        .quad_o   (quad_d)
    );

    always_comb begin
        state_d = state_q;
        if (!rst_n) begin
            state_d.mode  = cs_mode_e'(cs_mode_strap);
            state_d.cmd_a = '0;
            state_d.cmd_b = '0;
            state_d.cs_pa = '1;
            state_d.cs_pb = '1;
            state_d.cs_qd = '1;
            state_d.cke   = '0;
            state_d.odt   = '0;
        end else begin
            state_d.cmd_a = side_cmd_d[SIDE_A];
            state_d.cmd_b = side_cmd_d[SIDE_B];
            state_d.cs_pa = pair_a_d;
            state_d.cs_pb = pair_b_d;
            state_d.cs_qd = quad_d;
            state_d.cke   = cke_i;
            state_d.odt   = odt_i;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign cmd_a_o     = state_q.cmd_a;
    assign cmd_b_o     = state_q.cmd_b;
    assign cs_pair_a_o = state_q.cs_pa;
    assign cs_pair_b_o = state_q.cs_pb;
    assign cs_quad_o   = state_q.cs_qd;
    assign cke_o       = state_q.cke;
    assign odt_o       = state_q.odt;

    p_cmd_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cmd_a_o == $past(cmd_i));

    p_b_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(b_side_off)) |-> cmd_b_o == cmd_a_o);

    p_b_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(b_side_off)) |-> (cmd_b_o == '0 && cs_pair_b_o == '1));

    p_quad_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && state_q.mode == CS_PAIR) |-> cs_quad_o == '1);

    p_pair_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && state_q.mode == CS_QUAD) |-> (cs_pair_a_o == '1 && cs_pair_b_o == '1));

    p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(state_q.mode));

    p_ctl_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cke_o == $past(cke_i) && odt_o == $past(odt_i)));
endmodule

// File: tb/test_cmdbuf_top.sv
module test_cmdbuf_top;
    localparam int CMD_W = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strap = 1'b1;
    logic              b_off = 1'b0;
    logic [CMD_W-1:0]  cmd = '0;
    logic [3:0]        cs_n = '1;
    logic [1:0]        cke = '0;
    logic [1:0]        odt = '0;
    logic [CMD_W-1:0]  cmd_a, cmd_b;
    logic [1:0]        pa, pb, cke_q, odt_q;
    logic [3:0]        qd;

    int checks = 0;
    int fails  = 0;

    // bench-side reference state
    int               mode_m = 1;
    logic [CMD_W-1:0] e_cmd_a, e_cmd_b;
    logic [1:0]       e_pa, e_pb, e_cke, e_odt;
    logic [3:0]       e_qd;

    always #5 clk = ~clk;

    cmdbuf_top i_cmdbuf_top (
        .clk(clk), .rst_n(rst_n), .cs_mode_strap(strap), .b_side_off(b_off),
        .cmd_i(cmd), .cs_n_i(cs_n), .cke_i(cke), .odt_i(odt),
        .cmd_a_o(cmd_a), .cmd_b_o(cmd_b), .cs_pair_a_o(pa), .cs_pair_b_o(pb),
        .cs_quad_o(qd), .cke_o(cke_q), .odt_o(odt_q)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Builds the expected outputs from the inputs present at the coming edge.
    task automatic predict();
        if (!rst_n) begin
            mode_m  = int'(strap);
            e_cmd_a = '0; e_cmd_b = '0;
            e_pa = '1; e_pb = '1; e_qd = '1;
            e_cke = '0; e_odt = '0;
        end else begin
            e_cmd_a = cmd;
            e_cmd_b = b_off ? '0 : cmd;
            e_cke   = cke;
            e_odt   = odt;
            if (mode_m == 1) begin
                e_pa = cs_n[1:0];
                e_pb = b_off ? 2'b11 : cs_n[1:0];
                e_qd = '1;
            end else begin
                e_pa = '1; e_pb = '1;
                e_qd = cs_n;
            end
        end
    endtask

    task automatic step_and_compare(input bit in_reset);
        predict();
        @(posedge clk);
        @(negedge clk);
        if (in_reset) begin
            chk("R1 cs pair a", 64'(pa), 64'(e_pa));
            chk("R1 cs pair b", 64'(pb), 64'(e_pb));
            chk("R1 cs quad", 64'(qd), 64'(e_qd));
            chk("R1 cmd a", 64'(cmd_a), 64'(e_cmd_a));
            chk("R1 cmd b", 64'(cmd_b), 64'(e_cmd_b));
            chk("R1 cke/odt", 64'({cke_q, odt_q}), 64'({e_cke, e_odt}));
        end else begin
            chk("R2 cmd a", 64'(cmd_a), 64'(e_cmd_a));
            chk("R3/R4 cmd b", 64'(cmd_b), 64'(e_cmd_b));
            chk("R5/R4 cs pair a", 64'(pa), 64'(e_pa));
            chk("R5/R4 cs pair b", 64'(pb), 64'(e_pb));
            chk("R6 cs quad", 64'(qd), 64'(e_qd));
            chk("R8 cke", 64'(cke_q), 64'(e_cke));
            chk("R8 odt", 64'(odt_q), 64'(e_odt));
        end
    endtask

    task automatic randomize_inputs(input bit toggle_strap);
        cmd   = CMD_W'($urandom);
        cs_n  = 4'($urandom);
        cke   = 2'($urandom);
        odt   = 2'($urandom);
        b_off = ($urandom % 3) == 0;
        // R7: strap moves after reset; model keeps the mode latched in reset
        if (toggle_strap) strap = 1'($urandom);
    endtask

    task automatic run_mode(input logic strap_val);
        @(negedge clk);
        rst_n = 1'b0;
        strap = strap_val;
        cmd = '1; cke = '1; odt = '1; cs_n = '0; b_off = 1'b1;
        for (int i = 0; i < 3; i++) step_and_compare(1'b1);
        rst_n = 1'b1;
        for (int i = 0; i < 60; i++) begin
            randomize_inputs(i > 5);
            step_and_compare(1'b0);
        end
        // R5 / R6 explicit corners: upper selects active, lower idle
        strap = ~strap_val;
        b_off = 1'b0;
        cs_n  = 4'b0011;
        step_and_compare(1'b0);
        cs_n  = 4'b1110;
        step_and_compare(1'b0);
    endtask

    initial begin
        run_mode(1'b1);
        run_mode(1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule